// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides when a processor that owns an external memory bus by default may hand that bus to an off-chip master, and how it takes the bus back. The off-chip master asks with an active-low request line. The block answers with an active-low grant, and only after the bus cycle in progress has finished and any open DRAM bank has been precharged. Before the pads float, the control strobes are held at their inactive level for one cycle. Pad ownership is then given up in one step. It is won back in stages: grant negated, then control strobes driven, then address and data driven.

While the bus is lent out, an internal refresh demand makes the block negate the grant early. This asks the external master to let go. The bus is not resumed until the request line has been seen high on a set number of consecutive clock edges (two by default). A single high sample is treated as noise. The `bus_owned` output tells the local memory controller when it may start a new cycle. It is low in every state except full ownership.

Top module: `brel_arbiter`

## Requirements
- R1: During and straight after reset, `xgnt_n`=1, `ctl_oe`=1, `ctl_idle`=0, `ad_oe`=1 and `bus_owned`=1.
- R2: `xreq_n` is acted on only as sampled at the rising clock edge. A low pulse that starts and ends between two rising edges has no effect. With `xreq_n` high, ownership is kept on every cycle.
- R3: After a request is sampled, the block leaves full ownership. It enters the strobe-negate cycle only on an edge where `cyc_busy`=0 and, if `bank_open`=1, `pchg_done`=1. When these already hold at the request edge, it enters that cycle directly.
- R4: The strobe-negate cycle drives `ctl_oe`=1, `ctl_idle`=1 and `ad_oe`=1 for exactly one cycle. `ctl_oe` only ever falls after a cycle with `ctl_idle`=1.
- R5: `xgnt_n` falls on the same edge that `ctl_oe` and `ad_oe` fall. While `xgnt_n`=0, both enables stay 0.
- R6: If `xreq_n` is sampled high while the block is still waiting for the bus cycle or the precharge, the grant is abandoned and full ownership resumes on the next edge.
- R7: Leaving the released state needs `xreq_n` sampled high on NEG_MIN consecutive edges (default 2). A shorter high run leaves the bus released.
- R8: On the edge that completes the high run, `xgnt_n` rises with both enables still 0. `ctl_oe` rises on the next edge with `ctl_idle`=1. `ad_oe` and `bus_owned` rise on the edge after that.
- R9: A `rfsh_req` sampled high while granted raises `xgnt_n` on the next edge, with both enables still 0. The bus stays released until NEG_MIN consecutive high samples of `xreq_n`. On that edge `ctl_oe` rises, and `ad_oe` follows one edge later.
- R10: `bus_owned`=1 only when `xgnt_n`=1, `ctl_oe`=1, `ad_oe`=1 and `ctl_idle`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xreq_n | input | 1 | Off-chip bus request, active low |
| cyc_busy | input | 1 | A local bus cycle is still in progress |
| bank_open | input | 1 | A DRAM bank is open and needs precharge before release |
| pchg_done | input | 1 | Precharge of the open bank has completed |
| rfsh_req | input | 1 | Local refresh is pending and needs the bus |
| xgnt_n | output | 1 | Bus grant to the off-chip master, active low |
| ctl_oe | output | 1 | Output enable of the control strobe pads |
| ctl_idle | output | 1 | Forces control strobes to their inactive level |
| ad_oe | output | 1 | Output enable of the address and data pads |
| bus_owned | output | 1 | Local bus cycles may be launched |

## Verification
On every cycle, the assertions check the pad-ordering rules: enables off whenever the grant is low, a strobe-negate cycle before every tri-state, staged re-drive, and ownership only with every group driven. They also check the high-run length before handback, the refresh withdrawal, and that a new strobe-negate cycle starts only after the drain conditions held. The timing of the sequence under particular input histories can only be shown by the bench's scenarios. These include a glitch between edges, a request dropped mid-drain, a one-sample release pulse, and the direct path when the bus is already idle. A reference model compares every output on every cycle, including a long pseudo-random run.

// File: rtl/brel_pkg.sv
package brel_pkg;

  typedef enum logic [2:0] {
    ST_OWN      = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_NEGATE   = 3'd2,
    ST_RELEASED = 3'd3,
    ST_RECLAIM  = 3'd4,
    ST_HANDBACK = 3'd5,
    ST_CTLDRV   = 3'd6
  } brel_state_e;

  typedef struct packed {
    logic gnt_n;
    logic ctl_oe;
    logic ctl_idle;
    logic ad_oe;
    logic owned;
  } brel_drive_t;

  // Pad drive pattern held during each phase of the sequence.
  function automatic brel_drive_t drive_of(input brel_state_e s);
    brel_drive_t d;
    case (s)
      ST_OWN:      d = '{gnt_n: 1'b1, ctl_oe: 1'b1, ctl_idle: 1'b0, ad_oe: 1'b1, owned: 1'b1};
      ST_DRAIN:    d = '{gnt_n: 1'b1, ctl_oe: 1'b1, ctl_idle: 1'b0, ad_oe: 1'b1, owned: 1'b0};
      ST_NEGATE:   d = '{gnt_n: 1'b1, ctl_oe: 1'b1, ctl_idle: 1'b1, ad_oe: 1'b1, owned: 1'b0};
      ST_RELEASED: d = '{gnt_n: 1'b0, ctl_oe: 1'b0, ctl_idle: 1'b1, ad_oe: 1'b0, owned: 1'b0};
      ST_RECLAIM,
      ST_HANDBACK: d = '{gnt_n: 1'b1, ctl_oe: 1'b0, ctl_idle: 1'b1, ad_oe: 1'b0, owned: 1'b0};
      ST_CTLDRV:   d = '{gnt_n: 1'b1, ctl_oe: 1'b1, ctl_idle: 1'b1, ad_oe: 1'b0, owned: 1'b0};
      default:     d = '{gnt_n: 1'b1, ctl_oe: 1'b1, ctl_idle: 1'b0, ad_oe: 1'b1, owned: 1'b1};
    endcase
    return d;
  endfunction

  // The bus may be let go once no cycle runs and no bank is left open.
  function automatic logic drain_ok_f(input logic busy, input logic bank, input logic pchg);
    return !busy && (!bank || pchg);
  endfunction

  // True when the current high sample completes a run of run_min samples.
  function automatic logic run_done_f(input int unsigned prior, input logic hi,
                                      input int unsigned run_min);
    return hi && (prior + 1 >= run_min);
  endfunction

endpackage

// File: rtl/brel_drain_mon.sv
module brel_drain_mon (
  input  logic cyc_busy,
  input  logic bank_open,
  input  logic pchg_done,
  output logic drain_ok
);
  import brel_pkg::*;

  always_comb begin
    drain_ok = drain_ok_f(cyc_busy, bank_open, pchg_done);
  end
endmodule

// File: rtl/brel_neg_counter.sv
module brel_neg_counter #(
  parameter int unsigned NEG_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic xreq_n,
  output logic run_done
);
  import brel_pkg::*;

  localparam int unsigned CW = (NEG_MIN < 2) ? 1 : $clog2(NEG_MIN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!count_en || !xreq_n) begin
      run_q <= '0;
    end else if (int'(run_q) < int'(NEG_MIN)) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_comb begin
    run_done = count_en && run_done_f(int'(run_q), xreq_n, NEG_MIN);
  end
endmodule

// File: rtl/brel_seq.sv
module brel_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xreq_n,
  input  logic                  drain_ok,
  input  logic                  run_done,
  input  logic                  rfsh_req,
  output brel_pkg::brel_state_e state_d,
  output logic                  count_en
);
  import brel_pkg::*;

  brel_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWN;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OWN: begin
        if (!xreq_n) state_d = drain_ok ? ST_NEGATE : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (xreq_n)        state_d = ST_OWN;
        else if (drain_ok) state_d = ST_NEGATE;
      end
      ST_NEGATE:   state_d = ST_RELEASED;
      ST_RELEASED: begin
        if (run_done)      state_d = ST_HANDBACK;
        else if (rfsh_req) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (run_done) state_d = ST_CTLDRV;
      end
      ST_HANDBACK: state_d = ST_CTLDRV;
      ST_CTLDRV:   state_d = ST_OWN;
      default:     state_d = ST_OWN;
    endcase
  end

  always_comb begin
    count_en = (state_q == ST_RELEASED) || (state_q == ST_RECLAIM);
  end
endmodule

// File: rtl/brel_drive_reg.sv
module brel_drive_reg (
  input  logic                  clk,
  input  logic                  rst_n,
  input  brel_pkg::brel_state_e state_d,
  output brel_pkg::brel_drive_t drive_q
);
  import brel_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= drive_of(ST_OWN);
    else        drive_q <= drive_of(state_d);
  end
endmodule

// File: rtl/brel_arbiter.sv
module brel_arbiter #(
  parameter int unsigned NEG_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xreq_n,
  input  logic cyc_busy,
  input  logic bank_open,
  input  logic pchg_done,
  input  logic rfsh_req,
  output logic xgnt_n,
  output logic ctl_oe,
  output logic ctl_idle,
  output logic ad_oe,
  output logic bus_owned
);
  import brel_pkg::*;

  // Named internal events
  logic        drain_ok;
  logic        run_done;
  logic        count_en;
  brel_state_e state_d;
  brel_drive_t drive_q;

  brel_drain_mon u_drain (
    .cyc_busy  (cyc_busy),
    .bank_open (bank_open),
    .pchg_done (pchg_done),
    .drain_ok  (drain_ok)
  );

  brel_neg_counter #(.NEG_MIN(NEG_MIN)) u_negcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .xreq_n   (xreq_n),
    .run_done (run_done)
  );

  brel_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .xreq_n   (xreq_n),
    .drain_ok (drain_ok),
    .run_done (run_done),
    .rfsh_req (rfsh_req),
    .state_d  (state_d),
    .count_en (count_en)
  );

  brel_drive_reg u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .drive_q (drive_q)
  );

  assign xgnt_n    = drive_q.gnt_n;
  assign ctl_oe    = drive_q.ctl_oe;
  assign ctl_idle  = drive_q.ctl_idle;
  assign ad_oe     = drive_q.ad_oe;
  assign bus_owned = drive_q.owned;
endmodule

// File: rtl/brel_arbiter_chk.sv
module brel_arbiter_chk #(
  parameter int unsigned NEG_MIN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic xreq_n,
  input logic cyc_busy,
  input logic bank_open,
  input logic pchg_done,
  input logic rfsh_req,
  input logic xgnt_n,
  input logic ctl_oe,
  input logic ctl_idle,
  input logic ad_oe,
  input logic bus_owned
);
  localparam int unsigned HW = $clog2(NEG_MIN + 1) + 1;

  // Consecutive high samples of the request, counted independently.
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_cnt <= '0;
    else if (!xreq_n)                    hi_cnt <= '0;
    else if (int'(hi_cnt) < int'(NEG_MIN)) hi_cnt <= hi_cnt + 1'b1;
  end

  logic negate_phase;
  logic drain_phase;
  assign negate_phase = xgnt_n && ctl_oe && ctl_idle && ad_oe;
  assign drain_phase  = xgnt_n && ctl_oe && !ctl_idle && ad_oe && !bus_owned;

  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owned && xreq_n) |=> bus_owned);

  // R3
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(negate_phase) |-> $past(!cyc_busy && (!bank_open || pchg_done)));

  // R4
  negate_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(ctl_idle));

  // R5
  float_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xgnt_n |-> (!ctl_oe && !ad_oe));

  // R5
  grant_on_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> !xgnt_n);

  // R6
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_phase && xreq_n) |=> bus_owned);

  // R7
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xgnt_n) && !ctl_oe && !$past(rfsh_req)) |-> (int'(hi_cnt) >= int'(NEG_MIN)));

  // R8
  ctl_before_ad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(ctl_oe));

  // R8
  grant_before_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> ($past(xgnt_n) && !ad_oe));

  // R9
  refresh_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xgnt_n && rfsh_req) |=> (xgnt_n && !ad_oe));

  // R10
  owned_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_owned |-> (xgnt_n && ctl_oe && ad_oe && !ctl_idle));
endmodule

bind brel_arbiter brel_arbiter_chk #(.NEG_MIN(NEG_MIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xreq_n    (xreq_n),
  .cyc_busy  (cyc_busy),
  .bank_open (bank_open),
  .pchg_done (pchg_done),
  .rfsh_req  (rfsh_req),
  .xgnt_n    (xgnt_n),
  .ctl_oe    (ctl_oe),
  .ctl_idle  (ctl_idle),
  .ad_oe     (ad_oe),
  .bus_owned (bus_owned)
);

// File: tb/tb_brel_arbiter.sv
module tb_brel_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NEG_MIN    = 2;
  localparam int MAX_CYC    = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xreq_n = 1'b1, cyc_busy = 1'b0, bank_open = 1'b0, pchg_done = 1'b0, rfsh_req = 1'b0;
  logic xgnt_n, ctl_oe, ctl_idle, ad_oe, bus_owned;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brel_arbiter #(.NEG_MIN(NEG_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .xreq_n(xreq_n), .cyc_busy(cyc_busy),
    .bank_open(bank_open), .pchg_done(pchg_done), .rfsh_req(rfsh_req),
    .xgnt_n(xgnt_n), .ctl_oe(ctl_oe), .ctl_idle(ctl_idle), .ad_oe(ad_oe),
    .bus_owned(bus_owned)
  );

  wire [4:0] pins = {xgnt_n, ctl_oe, ctl_idle, ad_oe, bus_owned};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act[4:0], exp[4:0], $time);
    end
  endtask

  task automatic expect_pins(input string tag, input logic [4:0] exp);
    chk(pins === exp, tag, int'(pins), int'(exp));
  endtask

  // Behavioural reference: phase name and a count of high request samples.
  string phase = "own";
  int    hi_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = "own";
      hi_run = 0;
    end else begin
      bit idle_bus;
      idle_bus = !cyc_busy && (!bank_open || pchg_done);
      if (phase == "own") begin
        if (!xreq_n) phase = idle_bus ? "negate" : "drain";
      end else if (phase == "drain") begin
        if (xreq_n) phase = "own";
        else if (idle_bus) phase = "negate";
      end else if (phase == "negate") begin
        phase = "lent";
        hi_run = 0;
      end else if (phase == "lent" || phase == "recall") begin
        hi_run = xreq_n ? hi_run + 1 : 0;
        if (hi_run >= NEG_MIN) phase = (phase == "lent") ? "handback" : "ctl";
        else if (phase == "lent" && rfsh_req) phase = "recall";
      end else if (phase == "handback") begin
        phase = "ctl";
      end else begin
        phase = "own";
      end
    end
  end

  function automatic logic [4:0] model_pins(input string p);
    if (p == "own")    return 5'b11011;
    if (p == "drain")  return 5'b11010;
    if (p == "negate") return 5'b11110;
    if (p == "lent")   return 5'b00100;
    if (p == "ctl")    return 5'b11100;
    return 5'b10100;
  endfunction

  function automatic string model_tag(input string p);
    if (p == "own")    return "R10";
    if (p == "drain")  return "R3";
    if (p == "negate") return "R4";
    if (p == "lent")   return "R5";
    if (p == "recall") return "R9";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) expect_pins(model_tag(phase), model_pins(phase));
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    expect_pins("R1", 5'b11011);
    rst_n = 1'b1;
    @(negedge clk); expect_pins("R1", 5'b11011);

    // R2: idle with busy toggling, then a glitch between edges
    for (int i = 0; i < 4; i++) begin
      cyc_busy = i[0];
      @(negedge clk); expect_pins("R2", 5'b11011);
    end
    cyc_busy = 1'b0;
    #1 xreq_n = 1'b0;
    #2 xreq_n = 1'b1;
    @(negedge clk); expect_pins("R2", 5'b11011);
    @(negedge clk); expect_pins("R2", 5'b11011);

    // R3/R4/R5: request during a busy cycle with an open bank
    xreq_n = 1'b0; cyc_busy = 1'b1; bank_open = 1'b1; pchg_done = 1'b0;
    @(negedge clk); expect_pins("R3", 5'b11010);
    @(negedge clk); expect_pins("R3", 5'b11010); cyc_busy = 1'b0;
    @(negedge clk); expect_pins("R3", 5'b11010); pchg_done = 1'b1;
    @(negedge clk); expect_pins("R4", 5'b11110);
    @(negedge clk); expect_pins("R5", 5'b00100);
    bank_open = 1'b0; pchg_done = 1'b0;

    // R7: one high sample does not end the release
    xreq_n = 1'b1;
    @(negedge clk); expect_pins("R7", 5'b00100); xreq_n = 1'b0;
    @(negedge clk); expect_pins("R7", 5'b00100); xreq_n = 1'b1;
    @(negedge clk); expect_pins("R7", 5'b00100);
    // R8: staged handback
    @(negedge clk); expect_pins("R8", 5'b10100);
    @(negedge clk); expect_pins("R8", 5'b11100);
    @(negedge clk); expect_pins("R10", 5'b11011);

    // R6: request dropped while draining
    xreq_n = 1'b0; cyc_busy = 1'b1;
    @(negedge clk); expect_pins("R6", 5'b11010); xreq_n = 1'b1;
    @(negedge clk); expect_pins("R6", 5'b11011); cyc_busy = 1'b0;

    // R3 direct path, then R9 refresh recall
    xreq_n = 1'b0; bank_open = 1'b1; pchg_done = 1'b1;
    @(negedge clk); expect_pins("R3", 5'b11110);
    @(negedge clk); expect_pins("R5", 5'b00100);
    rfsh_req = 1'b1; bank_open = 1'b0; pchg_done = 1'b0;
    @(negedge clk); expect_pins("R9", 5'b10100); rfsh_req = 1'b0;
    @(negedge clk); expect_pins("R9", 5'b10100); xreq_n = 1'b1;
    @(negedge clk); expect_pins("R9", 5'b10100);
    @(negedge clk); expect_pins("R9", 5'b11100);
    @(negedge clk); expect_pins("R10", 5'b11011);

    // Pseudo-random run against the reference
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      xreq_n    = lf[3] | (lf[8] & lf[1]);
      cyc_busy  = lf[5] & lf[6];
      bank_open = lf[7];
      pchg_done = lf[9];
      rfsh_req  = lf[11] & lf[2] & lf[4];
      @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule